// File: doc/BRIEF.md
# Split-Lane Integer Execution Unit

This unit is the integer datapath of a small 16-bit processor. It takes the current contents of the destination register and of a source register. A 4-bit operation select chooses what to compute. The unit returns the 16-bit value that goes back into the destination register. Every arithmetic operation comes in two forms. The word form treats the operand as one 16-bit integer. The split form treats it as two independent 8-bit lanes: the high lane is bits 15:8 and the low lane is bits 7:0. In the split form, nothing crosses the lane boundary.

The unit is purely combinational, and the result follows the inputs within the same cycle. Internally, one 16-bit field unit serves the word forms. A generate loop builds one 8-bit field unit per lane for the split forms. A bitwise unit serves the four logic operations. A final selector picks the result that belongs to the operation. There is no state machine and no stored state.

Top module: `swar_int_alu`

## Requirements
- R1: `op_sel` encodes: 0 add word, 1 add lanes, 2 multiply word, 3 multiply lanes, 4 negate word, 5 negate lanes, 6 nonzero-mask word, 7 nonzero-mask lanes, 8 shift word, 9 shift lanes, 10 less-than word, 11 less-than lanes, 12 AND, 13 OR, 14 XOR, 15 NOT. In the lane forms, the lane in bits 15:8 and the lane in bits 7:0 never influence each other. For example, adding lanes 0x00FF and 0x0001 gives 0x0000.
- R2: Add returns `dst + src` modulo 2^16 (word form), or modulo 2^8 in each lane (lane forms).
- R3: Multiply returns the low 16 bits of `dst * src` (word form), or the low 8 bits of each lane product (lane forms).
- R4: Negate returns the two's-complement negation of `dst`, per field. The most negative value maps to itself: 0x8000 in the word form, and 0x80 in each lane.
- R5: The nonzero mask sets a field to all ones if any bit of that field of `dst` is set, and to zero otherwise.
- R6: Shift takes its amount from `src`, read as a signed field. A strictly positive amount shifts the `dst` field left by that amount, with zero fill.
- R7: A zero or negative amount shifts the field logically right by the negated amount. An amount of zero returns the field unchanged.
- R8: A shift whose magnitude is at least the field width gives zero. Examples are word amounts 16, -16 and -32768, and lane amounts 8, 127, -8 and -128.
- R9: Less-than writes 1 into a field when the signed `dst` field is below the signed `src` field, and 0 otherwise. All other bits of the field are zero.
- R10: AND, OR and XOR combine `dst` with `src` over all 16 bits. NOT inverts all 16 bits of `dst`, and `src` has no effect on it.
- R11: The result depends only on the present inputs. It settles within the cycle in which they change, and with all-zero inputs it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| dst_opnd | input | 16 | Destination register value, first operand |
| src_opnd | input | 16 | Source register value, second operand or shift amount |
| result | output | 16 | Value to write back into the destination register |

## Verification
The checker's properties are combinational. They are evaluated only while every input carries a known 0 or 1 value, because the unit gives no meaning to unknown operands. The properties also assume that `op_sel` holds one of the sixteen defined codes, which the 4-bit width guarantees. The bench drives every input fully before each sample and never leaves one floating. It changes the inputs one clock edge before it reads the result.

// File: rtl/swar_alu_pkg.sv
package swar_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD_W  = 4'd0,
        OP_ADD_L  = 4'd1,
        OP_MUL_W  = 4'd2,
        OP_MUL_L  = 4'd3,
        OP_NEG_W  = 4'd4,
        OP_NEG_L  = 4'd5,
        OP_NZM_W  = 4'd6,
        OP_NZM_L  = 4'd7,
        OP_SHF_W  = 4'd8,
        OP_SHF_L  = 4'd9,
        OP_SLT_W  = 4'd10,
        OP_SLT_L  = 4'd11,
        OP_AND    = 4'd12,
        OP_OR     = 4'd13,
        OP_XOR    = 4'd14,
        OP_NOT    = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        FK_ADD = 3'd0,
        FK_MUL = 3'd1,
        FK_NEG = 3'd2,
        FK_NZM = 3'd3,
        FK_SHF = 3'd4,
        FK_SLT = 3'd5
    } field_kind_e;

    typedef enum logic [1:0] {
        BK_AND = 2'd0,
        BK_OR  = 2'd1,
        BK_XOR = 2'd2,
        BK_NOT = 2'd3
    } bit_kind_e;

    typedef enum logic [1:0] {
        SRC_WORD  = 2'd0,
        SRC_LANES = 2'd1,
        SRC_BITS  = 2'd2
    } res_src_e;

    typedef struct packed {
        field_kind_e fkind;
        bit_kind_e   bkind;
        res_src_e    rsrc;
    } op_ctrl_t;

endpackage

// File: rtl/swar_op_decode.sv
module swar_op_decode
    import swar_alu_pkg::*;
(
    input  logic [3:0] op_code,
    output op_ctrl_t   ctrl
);
    alu_op_e op;

    always_comb begin
        op         = alu_op_e'(op_code);
        ctrl.fkind = FK_ADD;
        ctrl.bkind = BK_AND;
        ctrl.rsrc  = SRC_WORD;
        unique case (op)
            OP_ADD_W: begin ctrl.fkind = FK_ADD; ctrl.rsrc = SRC_WORD;  end
            OP_ADD_L: begin ctrl.fkind = FK_ADD; ctrl.rsrc = SRC_LANES; end
            OP_MUL_W: begin ctrl.fkind = FK_MUL; ctrl.rsrc = SRC_WORD;  end
            OP_MUL_L: begin ctrl.fkind = FK_MUL; ctrl.rsrc = SRC_LANES; end
            OP_NEG_W: begin ctrl.fkind = FK_NEG; ctrl.rsrc = SRC_WORD;  end
            OP_NEG_L: begin ctrl.fkind = FK_NEG; ctrl.rsrc = SRC_LANES; end
            OP_NZM_W: begin ctrl.fkind = FK_NZM; ctrl.rsrc = SRC_WORD;  end
            OP_NZM_L: begin ctrl.fkind = FK_NZM; ctrl.rsrc = SRC_LANES; end
            OP_SHF_W: begin ctrl.fkind = FK_SHF; ctrl.rsrc = SRC_WORD;  end
            OP_SHF_L: begin ctrl.fkind = FK_SHF; ctrl.rsrc = SRC_LANES; end
            OP_SLT_W: begin ctrl.fkind = FK_SLT; ctrl.rsrc = SRC_WORD;  end
            OP_SLT_L: begin ctrl.fkind = FK_SLT; ctrl.rsrc = SRC_LANES; end
            OP_AND:   begin ctrl.bkind = BK_AND; ctrl.rsrc = SRC_BITS;  end
            OP_OR:    begin ctrl.bkind = BK_OR;  ctrl.rsrc = SRC_BITS;  end
            OP_XOR:   begin ctrl.bkind = BK_XOR; ctrl.rsrc = SRC_BITS;  end
            OP_NOT:   begin ctrl.bkind = BK_NOT; ctrl.rsrc = SRC_BITS;  end
            default:  begin ctrl.rsrc = SRC_WORD; end
        endcase
    end
endmodule

// File: rtl/swar_field_unit.sv
module swar_field_unit
    import swar_alu_pkg::*;
#(
    parameter int FW = 8
) (
    input  field_kind_e     kind,
    input  logic [FW-1:0]   fa,
    input  logic [FW-1:0]   fb,
    output logic [FW-1:0]   fy
);
    localparam int MAGW = FW + 1;
    localparam logic [MAGW-1:0] WIDTH_LIM = MAGW'(FW);

    logic [MAGW-1:0] amt_ext;
    logic [MAGW-1:0] amt_mag;
    logic            amt_neg;
    logic            amt_pos;
    logic            too_far;
    logic [FW-1:0]   shifted;

    // Shift magnitude is carried one bit wider so the most negative
    // amount still has a representable magnitude.
    always_comb begin
        amt_neg = fb[FW-1];
        amt_pos = !amt_neg && (fb != '0);
        amt_ext = {fb[FW-1], fb};
        amt_mag = amt_neg ? (MAGW'(0) - amt_ext) : amt_ext;
        too_far = (amt_mag >= WIDTH_LIM);
        if (too_far)
            shifted = '0;
        else if (amt_pos)
            shifted = fa << amt_mag;
        else
            shifted = fa >> amt_mag;
    end

    always_comb begin
        fy = '0;
        unique case (kind)
            FK_ADD:  fy = fa + fb;
            FK_MUL:  fy = fa * fb;
            FK_NEG:  fy = FW'(0) - fa;
            FK_NZM:  fy = {FW{|fa}};
            FK_SHF:  fy = shifted;
            FK_SLT:  fy = {{(FW-1){1'b0}}, ($signed(fa) < $signed(fb))};
            default: fy = '0;
        endcase
    end
endmodule

// File: rtl/swar_bitwise_unit.sv
module swar_bitwise_unit
    import swar_alu_pkg::*;
#(
    parameter int BW = 16
) (
    input  bit_kind_e       kind,
    input  logic [BW-1:0]   ba,
    input  logic [BW-1:0]   bb,
    output logic [BW-1:0]   by
);
    always_comb begin
        by = '0;
        unique case (kind)
            BK_AND:  by = ba & bb;
            BK_OR:   by = ba | bb;
            BK_XOR:  by = ba ^ bb;
            BK_NOT:  by = ~ba;
            default: by = '0;
        endcase
    end
endmodule

// File: rtl/swar_int_alu.sv
module swar_int_alu
    import swar_alu_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic [3:0]              op_sel,
    input  logic [LANE_W*LANES-1:0] dst_opnd,
    input  logic [LANE_W*LANES-1:0] src_opnd,
    output logic [LANE_W*LANES-1:0] result
);
    localparam int WORD_W = LANE_W * LANES;

    op_ctrl_t          ctrl;
    logic [WORD_W-1:0] word_res;
    logic [WORD_W-1:0] lane_res;
    logic [WORD_W-1:0] bits_res;

    swar_op_decode u_dec (
        .op_code (op_sel),
        .ctrl    (ctrl)
    );

    swar_field_unit #(.FW(WORD_W)) u_word (
        .kind (ctrl.fkind),
        .fa   (dst_opnd),
        .fb   (src_opnd),
        .fy   (word_res)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        swar_field_unit #(.FW(LANE_W)) u_lane (
            .kind (ctrl.fkind),
            .fa   (dst_opnd[g*LANE_W +: LANE_W]),
            .fb   (src_opnd[g*LANE_W +: LANE_W]),
            .fy   (lane_res[g*LANE_W +: LANE_W])
        );
    end

    swar_bitwise_unit #(.BW(WORD_W)) u_bits (
        .kind (ctrl.bkind),
        .ba   (dst_opnd),
        .bb   (src_opnd),
        .by   (bits_res)
    );

    always_comb begin
        result = '0;
        unique case (ctrl.rsrc)
            SRC_WORD:  result = word_res;
            SRC_LANES: result = lane_res;
            SRC_BITS:  result = bits_res;
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/swar_int_alu_chk.sv
module swar_int_alu_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input logic [3:0]              op_sel,
    input logic [LANE_W*LANES-1:0] dst_opnd,
    input logic [LANE_W*LANES-1:0] src_opnd,
    input logic [LANE_W*LANES-1:0] result
);
    localparam int WORD_W = LANE_W * LANES;

    always_comb begin
        if (!$isunknown({op_sel, dst_opnd, src_opnd, result})) begin
            // R10
            not_inverts_chk: assert (op_sel != 4'd15 || (result ^ dst_opnd) == {WORD_W{1'b1}})
                else $error("NOT result is not the inverse of the operand");
            // R10
            xor_undo_chk: assert (op_sel != 4'd14 || (result ^ src_opnd) == dst_opnd)
                else $error("XOR result does not undo with the source");
            // R4
            neg_word_sum_chk: assert (op_sel != 4'd4 || WORD_W'(result + dst_opnd) == '0)
                else $error("word negate plus operand is not zero");
            // R5
            nzm_word_chk: assert (op_sel != 4'd6 ||
                                  result == ((dst_opnd != '0) ? {WORD_W{1'b1}} : '0))
                else $error("word nonzero mask wrong");
            // R9
            slt_word_chk: assert (op_sel != 4'd10 || result[WORD_W-1:1] == '0)
                else $error("word less-than upper bits set");
            // R7
            shift_zero_word_chk: assert (op_sel != 4'd8 || src_opnd != '0 || result == dst_opnd)
                else $error("word shift by zero changed the value");
            for (int i = 0; i < LANES; i++) begin
                // R4
                neg_lane_sum_chk: assert (op_sel != 4'd5 ||
                    LANE_W'(result[i*LANE_W +: LANE_W] + dst_opnd[i*LANE_W +: LANE_W]) == '0)
                    else $error("lane negate plus operand is not zero");
                // R5
                nzm_lane_chk: assert (op_sel != 4'd7 ||
                    result[i*LANE_W +: LANE_W] ==
                    ((dst_opnd[i*LANE_W +: LANE_W] != '0) ? {LANE_W{1'b1}} : {LANE_W{1'b0}}))
                    else $error("lane nonzero mask wrong");
                // R7
                shift_zero_lane_chk: assert (op_sel != 4'd9 ||
                    src_opnd[i*LANE_W +: LANE_W] != '0 ||
                    result[i*LANE_W +: LANE_W] == dst_opnd[i*LANE_W +: LANE_W])
                    else $error("lane shift by zero changed the lane");
            end
        end
    end
endmodule

bind swar_int_alu swar_int_alu_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .op_sel   (op_sel),
    .dst_opnd (dst_opnd),
    .src_opnd (src_opnd),
    .result   (result)
);

// File: tb/tb_swar_int_alu.sv
module tb_swar_int_alu;
    logic        clk;
    logic        rst_n;
    logic [3:0]  op_sel;
    logic [15:0] dst_opnd;
    logic [15:0] src_opnd;
    logic [15:0] result;
    int          n_run;
    int          n_fail;
    bit          done;

    swar_int_alu dut (
        .op_sel   (op_sel),
        .dst_opnd (dst_opnd),
        .src_opnd (src_opnd),
        .result   (result)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Reference written from the requirements: field value as integers.
    function automatic longint fld(int kind, int w, longint a, longint b);
        longint m   = (longint'(1) << w) - 1;
        longint sa  = (a >= (longint'(1) << (w-1))) ? a - (longint'(1) << w) : a;
        longint sb  = (b >= (longint'(1) << (w-1))) ? b - (longint'(1) << w) : b;
        longint r   = 0;
        case (kind)
            0: r = (a + b) & m;
            1: r = (a * b) & m;
            2: r = (-a) & m;
            3: r = (a != 0) ? m : 0;
            4: begin
                if (sb > 0) r = (sb >= w) ? 0 : ((a << sb) & m);
                else        r = (-sb >= w) ? 0 : (a >> (-sb));
            end
            5: r = (sa < sb) ? 1 : 0;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] ref_calc(int op, logic [15:0] d, logic [15:0] s);
        int kind = op / 2;
        if (op >= 12) begin
            case (op)
                12: return d & s;
                13: return d | s;
                14: return d ^ s;
                default: return ~d;
            endcase
        end
        if (op % 2 == 0) return 16'(fld(kind, 16, longint'(d), longint'(s)));
        return {8'(fld(kind, 8, longint'(d[15:8]), longint'(s[15:8]))),
                8'(fld(kind, 8, longint'(d[7:0]), longint'(s[7:0])))};
    endfunction

    task automatic apply(int op, logic [15:0] d, logic [15:0] s);
        @(posedge clk);
        op_sel   = 4'(op);
        dst_opnd = d;
        src_opnd = s;
        @(negedge clk);
    endtask

    task automatic check(string req, int op, logic [15:0] d, logic [15:0] s, logic [15:0] exp);
        apply(op, d, s);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d d=%h s=%h actual=%h expected=%h", req, op, d, s, result, exp);
        end
    endtask

    task automatic test_reset_state();
        // R11: all-zero inputs give zero
        check("R11", 0, 16'h0000, 16'h0000, 16'h0000);
    endtask

    task automatic test_lane_isolation();
        check("R1", 1, 16'h00FF, 16'h0001, 16'h0000);
        check("R1", 1, 16'h7FFF, 16'h0101, 16'h8000);
        check("R2", 0, 16'h00FF, 16'h0001, 16'h0100);
        check("R2", 0, 16'hFFFF, 16'h0002, 16'h0001);
    endtask

    task automatic test_multiply();
        check("R3", 2, 16'h0100, 16'h0100, 16'h0000);
        check("R3", 2, 16'h1234, 16'h0003, 16'h369C);
        check("R3", 3, 16'h1010, 16'h1011, 16'h0010);
        check("R3", 3, 16'hFF03, 16'hFF05, 16'h010F);
    endtask

    task automatic test_negate();
        check("R4", 4, 16'h8000, 16'h1234, 16'h8000);
        check("R4", 4, 16'h0001, 16'h0000, 16'hFFFF);
        check("R4", 5, 16'h8080, 16'h0000, 16'h8080);
        check("R4", 5, 16'h0100, 16'h0000, 16'hFF00);
    endtask

    task automatic test_mask();
        check("R5", 6, 16'h0100, 16'h0000, 16'hFFFF);
        check("R5", 6, 16'h0000, 16'hFFFF, 16'h0000);
        check("R5", 7, 16'h0100, 16'h0000, 16'hFF00);
        check("R5", 7, 16'h0080, 16'h0000, 16'h00FF);
    endtask

    task automatic test_shift();
        check("R6", 8, 16'h0001, 16'h000F, 16'h8000);
        check("R6", 9, 16'h0101, 16'h0107, 16'h0280);
        check("R7", 8, 16'hA5A5, 16'h0000, 16'hA5A5);
        check("R7", 8, 16'h8000, 16'hFFF1, 16'h0001);
        check("R7", 9, 16'h8080, 16'hFF00, 16'h4080);
        check("R8", 8, 16'hFFFF, 16'h0010, 16'h0000);
        check("R8", 8, 16'hFFFF, 16'hFFF0, 16'h0000);
        check("R8", 8, 16'hFFFF, 16'h8000, 16'h0000);
        check("R8", 9, 16'hFFFF, 16'h0878, 16'h0000);
        check("R8", 9, 16'hFFFF, 16'hF880, 16'h0000);
        check("R8", 9, 16'hFFFF, 16'h7F07, 16'h0080);
    endtask

    task automatic test_less_than();
        check("R9", 10, 16'h8000, 16'h7FFF, 16'h0001);
        check("R9", 10, 16'h7FFF, 16'h8000, 16'h0000);
        check("R9", 10, 16'h0005, 16'h0005, 16'h0000);
        check("R9", 11, 16'h8001, 16'h0080, 16'h0100);
    endtask

    task automatic test_bitwise();
        check("R10", 12, 16'hF0F0, 16'hFF00, 16'hF000);
        check("R10", 13, 16'hF0F0, 16'h0F00, 16'hFFF0);
        check("R10", 14, 16'hF0F0, 16'hFF00, 16'h0FF0);
        check("R10", 15, 16'h1234, 16'h0000, 16'hEDCB);
        check("R10", 15, 16'h1234, 16'hFFFF, 16'hEDCB);
    endtask

    task automatic test_random();
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 150; k++) begin
                logic [15:0] d = 16'($urandom);
                logic [15:0] s = 16'($urandom);
                if (op == 8 || op == 9) s = (k % 2 == 0) ? s : (s & 16'h0F0F) ^ {{4{s[15]}}, 4'h0, {4{s[7]}}, 4'h0};
                check((op < 12) ? "R2" : "R10", op, d, s, ref_calc(op, d, s));
            end
        end
    endtask

    initial begin
        n_run    = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        op_sel   = 4'd0;
        dst_opnd = 16'h0000;
        src_opnd = 16'h0000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_lane_isolation();
        test_multiply();
        test_negate();
        test_mask();
        test_shift();
        test_less_than();
        test_bitwise();
        test_random();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule